// File: doc/BRIEF.md
# Condition Evaluator and Conditional Select

This block tests one of sixteen 4-bit condition codes against the four processor flags (negative, zero, carry, overflow) and uses the outcome to choose a 64-bit result from two source operands. When the condition holds, the result is the first operand. When it fails, the result is the second operand after an optional transform: none, add one, bitwise invert, or two's-complement negate. The raw condition-true bit is also brought out, so the same evaluator can steer a conditional branch.

Two further controls change the arithmetic. A narrow (32-bit) mode performs the operation on the low 32 bits and clears bits 63:32 of the result. A set-on-condition mode produces 1 or 0 from the condition alone. It is built from the add-one path, with both operands forced to zero and the condition inverted. Inputs are captured on a clock edge, and both outputs are registered with a synchronous active-high reset.

Top module: `csel_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `cond_true` become 0 after that edge.
- R2: Outputs change only on a rising clock edge, one cycle after the inputs are sampled. Between edges they hold their value.
- R3: `flags_nzcv` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. The codes evaluate as follows: 0 is true when Z=1, and 1 when Z=0. Code 2 is true when C=1, and 3 when C=0. Code 4 is true when N=1, and 5 when N=0. Code 6 is true when V=1, and 7 when V=0.
- R4: Code 8 is true when C=1 and Z=0. Code 9 is true when C=0 or Z=1.
- R5: Code 10 is true when N equals V, and code 11 when N differs from V. Code 12 is true when Z=0 and N equals V. Code 13 is true when Z=1 or N differs from V.
- R6: Codes 14 and 15 are always true, whatever the flags.
- R7: When the condition is true, `result` is `src_a`, whatever `sel_kind` is. With `sel_kind`=0 and a false condition, `result` is `src_b`.
- R8: With `sel_kind`=1 and a false condition, `result` is `src_b`+1, wrapping modulo 2^64.
- R9: With `sel_kind`=2 and a false condition, `result` is the bitwise inverse of `src_b`.
- R10: With `sel_kind`=3 and a false condition, `result` is 0-`src_b` modulo 2^64. Negating 0 gives 0, and negating 2^63 gives 2^63.
- R11: With `narrow_mode`=1, the increment and negate are done on 32 bits. Bits 63:32 of `result` are 0 on either path.
- R12: With `set_mode`=1, `result` is 1 when the condition holds and 0 otherwise, whatever `src_a`, `src_b` and `sel_kind` are. In this mode `cond_true` still reports the condition as evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition code, 0..15 |
| flags_nzcv | input | 4 | Flags: N bit 3, Z bit 2, C bit 1, V bit 0 |
| sel_kind | input | 2 | False-path transform: 0 none, 1 add one, 2 invert, 3 negate |
| narrow_mode | input | 1 | 32-bit operation with bits 63:32 cleared |
| set_mode | input | 1 | Set-on-condition: result is 1 or 0 |
| src_a | input | 64 | Operand chosen when the condition holds |
| src_b | input | 64 | Operand transformed when the condition fails |
| result | output | 64 | Registered selected result |
| cond_true | output | 1 | Registered raw condition outcome |

## Verification
The hardest cases to reach are the arithmetic edges of the false path. These are an increment that wraps all ones to zero, negation of zero and of the most negative value, and, in narrow mode, a carry out of bit 31 that has to vanish while dirty upper operand bits are discarded. The stimulus reaches them by pairing a failing condition with operands built for each edge: all ones, zero, 2^63, and low words of FFFFFFFF or 00000001 under non-zero upper halves. Set-on-condition mode is driven with non-zero operands and a negate kind, to show that both operands and the kind are ignored.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef enum logic [1:0] {
    SK_PLAIN = 2'd0,
    SK_INC   = 2'd1,
    SK_INV   = 2'd2,
    SK_NEG   = 2'd3
  } sel_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       hit
);

  // Codes come in pairs: the odd member is the complement of the even one,
  // except the last pair, where both members are always true.
  localparam int NPAIR = 8;
  localparam int NCODE = 2 * NPAIR;

  flags_t             f;
  logic [NPAIR-1:0]   base;
  logic [NCODE-1:0]   outcome;

  assign f = nzcv;

  always_comb begin
    base[0] = f.z;
    base[1] = f.c;
    base[2] = f.n;
    base[3] = f.v;
    base[4] = f.c & ~f.z;
    base[5] = ~(f.n ^ f.v);
    base[6] = ~f.z & ~(f.n ^ f.v);
    base[7] = 1'b1;
  end

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign outcome[2*p] = base[p];
      if (p == NPAIR - 1) begin : g_always
        assign outcome[2*p+1] = 1'b1;
      end else begin : g_compl
        assign outcome[2*p+1] = ~base[p];
      end
    end
  endgenerate

  assign hit = outcome[code];

endmodule

// File: rtl/csel_alt_path.sv
module csel_alt_path
  import csel_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] opnd,
  input  logic [1:0]   kind,
  output logic [W-1:0] alt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (sel_kind_e'(kind))
      SK_INC:  alt = opnd + ONE;
      SK_INV:  alt = ~opnd;
      SK_NEG:  alt = '0 - opnd;
      default: alt = opnd;
    endcase
  end

endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond_code,
  input  logic [3:0]        flags_nzcv,
  input  logic [1:0]        sel_kind,
  input  logic              narrow_mode,
  input  logic              set_mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              cond_true
);

  localparam int UPPER_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};

  logic              raw_hit;
  logic              eff_hit;
  logic [1:0]        eff_kind;
  logic [DATA_W-1:0] op_a, op_b, alt_val, picked, next_res;
  logic              past_ok;

  csel_cond_eval u_eval (
    .code (cond_code),
    .nzcv (flags_nzcv),
    .hit  (raw_hit)
  );

  // Set-on-condition reuses the add-one path: zero operands, inverted test.
  always_comb begin
    eff_hit  = set_mode ? ~raw_hit : raw_hit;
    eff_kind = set_mode ? SK_INC : sel_kind;
    op_a     = set_mode ? '0 : src_a;
    op_b     = set_mode ? '0 : src_b;
  end

  csel_alt_path #(.W(DATA_W)) u_alt (
    .opnd (op_b),
    .kind (eff_kind),
    .alt  (alt_val)
  );

  // The low bits of a wide add or negate equal the narrow result, so masking
  // the upper half is enough for 32-bit mode.
  always_comb begin
    picked   = eff_hit ? op_a : alt_val;
    next_res = narrow_mode ? (picked & NARROW_MASK) : picked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      cond_true <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      result    <= next_res;
      cond_true <= raw_hit;
      past_ok   <= 1'b1;
    end
  end

  // Condition codes 14 and 15 yield true for every flag value.
  p_always_true_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cond_code) >= 4'd14) |-> cond_true);

  // The true path passes src_a through untouched in full-width mode.
  p_true_path_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cond_true && !$past(set_mode) && !$past(narrow_mode))
      |-> result == $past(src_a));

  // The invert kind yields the complement of src_b on a failed test.
  p_invert_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !cond_true && !$past(set_mode) && !$past(narrow_mode)
     && $past(sel_kind) == 2'd2) |-> result == ~$past(src_b));

  // Narrow mode never leaves a bit set above the narrow width.
  p_narrow_upper_r11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(narrow_mode)) |-> result[DATA_W-1:NARROW_W] == '0);

  // Set-on-condition gives a single bit that matches the reported condition.
  p_set_binary_r12: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(set_mode)) |-> result == DATA_W'(cond_true));

  // After a reset edge both outputs are clear.
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !cond_true));

endmodule

// File: tb/csel_unit_tb.sv
module csel_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int NVEC = 21;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [3:0]    code;
    logic [3:0]    flags;
    logic [1:0]    kind;
    logic          narrow;
    logic          setm;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] exp_res;
    logic          exp_cond;
    logic [3:0]    req;
  } vec_t;

  localparam logic [DW-1:0] A0 = 64'h1111_2222_3333_4444;
  localparam logic [DW-1:0] B0 = 64'h0000_0000_0000_0005;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  4'b0100, 2'd0, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd3},                          // R3 EQ true
    '{4'd0,  4'b0000, 2'd0, 1'b0, 1'b0, A0, B0, B0, 1'b0, 4'd7},                          // R7 plain false
    '{4'd3,  4'b0010, 2'd1, 1'b0, 1'b0, A0, B0, 64'd6, 1'b0, 4'd8},                       // R8 inc
    '{4'd8,  4'b0010, 2'd0, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd4},                          // R4 HI true
    '{4'd8,  4'b0110, 2'd2, 1'b0, 1'b0, A0, B0, 64'hFFFF_FFFF_FFFF_FFFA, 1'b0, 4'd9},     // R9 invert
    '{4'd9,  4'b0000, 2'd0, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd4},                          // R4 LS true
    '{4'd10, 4'b1001, 2'd0, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd5},                          // R5 GE true
    '{4'd11, 4'b1001, 2'd3, 1'b0, 1'b0, A0, B0, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 4'd10},    // R10 negate
    '{4'd12, 4'b0100, 2'd0, 1'b0, 1'b0, A0, B0, B0, 1'b0, 4'd5},                          // R5 GT false
    '{4'd13, 4'b1000, 2'd0, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd5},                          // R5 LE true
    '{4'd14, 4'b0000, 2'd3, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd6},                          // R6 code 14
    '{4'd15, 4'b1111, 2'd3, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd6},                          // R6 code 15
    '{4'd1,  4'b0100, 2'd1, 1'b0, 1'b0, A0, '1, 64'd0, 1'b0, 4'd8},                       // R8 wrap
    '{4'd1,  4'b0100, 2'd3, 1'b0, 1'b0, A0, 64'd0, 64'd0, 1'b0, 4'd10},                   // R10 neg zero
    '{4'd4,  4'b0000, 2'd3, 1'b0, 1'b0, A0, 64'h8000_0000_0000_0000,
      64'h8000_0000_0000_0000, 1'b0, 4'd10},                                              // R10 neg min
    '{4'd6,  4'b0000, 2'd1, 1'b1, 1'b0, A0, 64'h1234_5678_FFFF_FFFF, 64'd0, 1'b0, 4'd11}, // R11 narrow inc
    '{4'd7,  4'b0001, 2'd3, 1'b1, 1'b0, A0, 64'hAAAA_AAAA_0000_0001,
      64'h0000_0000_FFFF_FFFF, 1'b0, 4'd11},                                              // R11 narrow neg
    '{4'd5,  4'b0000, 2'd0, 1'b1, 1'b0, A0, B0, 64'h0000_0000_3333_4444, 1'b1, 4'd11},    // R11 narrow true
    '{4'd0,  4'b0100, 2'd3, 1'b0, 1'b1, A0, B0, 64'd1, 1'b1, 4'd12},                      // R12 set true
    '{4'd0,  4'b0000, 2'd3, 1'b0, 1'b1, A0, B0, 64'd0, 1'b0, 4'd12},                      // R12 set false
    '{4'd2,  4'b0010, 2'd2, 1'b0, 1'b0, A0, B0, A0, 1'b1, 4'd3}                           // R3 CS true
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    cond_code = '0;
  logic [3:0]    flags_nzcv = '0;
  logic [1:0]    sel_kind = '0;
  logic          narrow_mode = 1'b0;
  logic          set_mode = 1'b0;
  logic [DW-1:0] src_a = '0;
  logic [DW-1:0] src_b = '0;
  logic [DW-1:0] result;
  logic          cond_true;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_unit u_dut (
    .clk         (clk),
    .rst         (rst),
    .cond_code   (cond_code),
    .flags_nzcv  (flags_nzcv),
    .sel_kind    (sel_kind),
    .narrow_mode (narrow_mode),
    .set_mode    (set_mode),
    .src_a       (src_a),
    .src_b       (src_b),
    .result      (result),
    .cond_true   (cond_true)
  );

  task automatic check(input string req, input logic [DW-1:0] exp_res, input logic exp_c);
    n_checks++;
    if (result !== exp_res || cond_true !== exp_c) begin
      n_fail++;
      $display("FAIL %s: result=%h cond=%b expected result=%h cond=%b",
               req, result, cond_true, exp_res, exp_c);
    end
  endtask

  task automatic drive(input vec_t v);
    cond_code   = v.code;
    flags_nzcv  = v.flags;
    sel_kind    = v.kind;
    narrow_mode = v.narrow;
    set_mode    = v.setm;
    src_a       = v.a;
    src_b       = v.b;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_res, VECS[i].exp_cond);
    end

    // R2: new inputs do not reach the outputs before the next edge.
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    check("R2 settle", A0, 1'b1);
    drive(VECS[1]);
    #1;
    check("R2 hold before edge", A0, 1'b1);
    @(negedge clk);
    check("R2 after edge", B0, 1'b0);

    // R1: reset in mid-run clears the outputs even with a true condition applied.
    drive(VECS[10]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset", A0, 1'b1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule